// File: doc/BRIEF.md
# Four-Bank Interleaved Line Refill Controller

This block answers cache-line refill requests from a main memory built as four word-wide banks. The cache side presents a line address together with a request strobe. The controller sends that one address to every bank at the same time, and all four banks then run their long access in parallel. When the access is complete, the four words come back one after another over a single word-wide return bus. Each word carries a valid strobe, and the fourth word also carries a last-word flag.

The banks are modelled inside the block as read-only arrays. Each array has its contents filled from a fixed formula, which stands in for real memory. The costs are fixed: 4 cycles to move the address, 56 cycles of bank access, and 4 cycles for each word transfer. The last word of a line therefore appears 4 + 56 + 4×4 = 76 cycles after the request is accepted. A one-at-a-time arrangement would instead need four complete 64-cycle accesses.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: While `rst` is high, `busy`, `rsp_valid` and `rsp_last` are driven low from the first clock edge onward.
- R2: A request seen while `busy` is high is ignored. It does not change the words, timing or count of the refill in progress, and `busy` stays low once that refill ends.
- R3: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the cycle after that edge until the edge that presents the last word. On that edge `busy` drops.
- R4: `rsp_valid` pulses for exactly one cycle per word. The first pulse appears 64 cycles after the acceptance edge, and the next three follow at 4-cycle spacing.
- R5: `rsp_last` is high only together with the fourth word of a line, exactly 76 cycles after the acceptance edge.
- R6: Words return in bank order 0, 1, 2, 3. The word with index k is the memory word at global address g = line×4 + k, which sits in bank k (the two low bits of g) at row `line` (the upper bits of g).
- R7: The memory word at global address g holds (g × 0x9E3779B1 + 0x0BADF00D) mod 2^32.
- R8: A request held high across the end of a refill is accepted on the first edge after `busy` falls. That next refill shows the same 76-cycle timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request strobe |
| req_line | input | LINE_AW (8) | Line address; also the row inside each bank |
| busy | output | 1 | Refill in progress; new requests are not taken |
| rsp_valid | output | 1 | Returned word is valid this cycle |
| rsp_last | output | 1 | Returned word is the fourth word of the line |
| rsp_data | output | DATA_W (32) | Returned word |

## Verification
Suppose the phase counter or the beat index held a wrong value. Then `rsp_valid` would move off its 64/68/72/76-cycle slots, or `rsp_last` would land on the wrong word, and the cycle-exact reference comparison would catch it within one refill. A fault in bank selection or row addressing would show up as a data mismatch on the first returned word that uses the faulty bank. A wrong idle/busy decision would show either as a refill that starts during another refill or as a gap before a back-to-back request is taken. Both of these show on `busy` within a single cycle of the offending edge.

// File: rtl/ilv_refill_pkg.sv
package ilv_refill_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SEND,
    PH_ACCESS,
    PH_XFER
  } phase_t;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int          DATA_W    = 32,
  parameter int          ROW_AW    = 8,
  parameter int          NBANK     = 4,
  parameter int          BANK_ID   = 0,
  parameter logic [31:0] FILL_MULT = 32'h9E37_79B1,
  parameter logic [31:0] FILL_SEED = 32'h0BAD_F00D
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ROW_AW-1:0] rd_row,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ROW_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // contents stand in for main memory: a word depends on its global address
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(64'(i * NBANK + BANK_ID) * 64'(FILL_MULT) + 64'(FILL_SEED));
    end
  end

  // registered read port, block RAM style
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_row];
  end

endmodule

// File: rtl/ilv_refill_seq.sv
module ilv_refill_seq
  import ilv_refill_pkg::*;
#(
  parameter int LINE_AW   = 8,
  parameter int NBANK     = 4,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 56,
  parameter int XFER_CYC  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [LINE_AW-1:0]       req_line,
  output logic                     busy,
  output logic [LINE_AW-1:0]       line_q,
  output logic                     bank_rd,
  output logic                     beat_fire,
  output logic                     beat_last,
  output logic [$clog2(NBANK)-1:0] beat_idx
);

  localparam int MAXC  = max3(ADDR_CYC, ACC_CYC, XFER_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BSEL_W = $clog2(NBANK);

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic               cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign bank_rd   = (phase == PH_ACCESS) && cnt_zero;
  assign beat_fire = (phase == PH_XFER) && cnt_zero;
  assign beat_last = (beat_idx == BSEL_W'(NBANK - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      beat_idx <= '0;
      busy     <= 1'b0;
      line_q   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase  <= PH_SEND;
            cnt    <= CNT_W'(ADDR_CYC - 1);
            line_q <= req_line;
            busy   <= 1'b1;
          end
        end
        PH_SEND: begin
          if (cnt_zero) begin
            phase <= PH_ACCESS;
            cnt   <= CNT_W'(ACC_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ACCESS: begin
          if (cnt_zero) begin
            phase    <= PH_XFER;
            cnt      <= CNT_W'(XFER_CYC - 1);
            beat_idx <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_XFER: begin
          if (cnt_zero) begin
            if (beat_last) begin
              phase <= PH_IDLE;
              busy  <= 1'b0;
            end else begin
              beat_idx <= beat_idx + 1'b1;
              cnt      <= CNT_W'(XFER_CYC - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl #(
  parameter int          DATA_W    = 32,
  parameter int          LINE_AW   = 8,
  parameter int          NBANK     = 4,
  parameter int          ADDR_CYC  = 4,
  parameter int          ACC_CYC   = 56,
  parameter int          XFER_CYC  = 4,
  parameter logic [31:0] FILL_MULT = 32'h9E37_79B1,
  parameter logic [31:0] FILL_SEED = 32'h0BAD_F00D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [LINE_AW-1:0] req_line,
  output logic               busy,
  output logic               rsp_valid,
  output logic               rsp_last,
  output logic [DATA_W-1:0]  rsp_data
);

  localparam int BSEL_W = $clog2(NBANK);

  logic [LINE_AW-1:0]           line_q;
  logic                         bank_rd;
  logic                         beat_fire;
  logic                         beat_last;
  logic [BSEL_W-1:0]            beat_idx;
  logic [NBANK-1:0][DATA_W-1:0] bank_dout;

  ilv_refill_seq #(
    .LINE_AW (LINE_AW),
    .NBANK   (NBANK),
    .ADDR_CYC(ADDR_CYC),
    .ACC_CYC (ACC_CYC),
    .XFER_CYC(XFER_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_line (req_line),
    .busy     (busy),
    .line_q   (line_q),
    .bank_rd  (bank_rd),
    .beat_fire(beat_fire),
    .beat_last(beat_last),
    .beat_idx (beat_idx)
  );

  // one broadcast row address, all banks read on the same edge
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank #(
      .DATA_W   (DATA_W),
      .ROW_AW   (LINE_AW),
      .NBANK    (NBANK),
      .BANK_ID  (b),
      .FILL_MULT(FILL_MULT),
      .FILL_SEED(FILL_SEED)
    ) u_bank (
      .clk    (clk),
      .rd_en  (bank_rd),
      .rd_row (line_q),
      .rd_data(bank_dout[b])
    );
  end

  // serialized return over the shared word bus
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
    end else begin
      rsp_valid <= beat_fire;
      rsp_last  <= beat_fire && beat_last;
    end
    if (beat_fire) rsp_data <= bank_dout[beat_idx];
  end

endmodule

// File: rtl/ilv_refill_ctrl_chk.sv
module ilv_refill_ctrl_chk #(
  parameter int NBANK     = 4,
  parameter int TOTAL_CYC = 76
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic rsp_valid,
  input logic rsp_last
);

  logic [31:0] since;
  logic [7:0]  beats;
  logic        track;

  always_ff @(posedge clk) begin
    if (rst) begin
      track <= 1'b0;
      since <= '0;
      beats <= '0;
    end else if (req_valid && !busy) begin
      track <= 1'b1;
      since <= '0;
      beats <= '0;
    end else if (track) begin
      since <= since + 1'b1;
      if (rsp_valid) beats <= beats + 1'b1;
      if (rsp_last)  track <= 1'b0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !rsp_valid && !rsp_last));

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_last);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2
  beat_count_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (track && beats < 8'(NBANK)));

  // R5
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> rsp_valid);

  // R5
  last_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> (since == 32'(TOTAL_CYC) && beats == 8'(NBANK - 1)));

endmodule

bind ilv_refill_ctrl ilv_refill_ctrl_chk #(
  .NBANK    (NBANK),
  .TOTAL_CYC(ADDR_CYC + ACC_CYC + NBANK * XFER_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .busy     (busy),
  .rsp_valid(rsp_valid),
  .rsp_last (rsp_last)
);

// File: tb/ilv_refill_ctrl_bench.sv
module ilv_refill_ctrl_bench;

  localparam int FIRST  = 64;
  localparam int STEP   = 4;
  localparam int WORDS  = 4;
  localparam int TOTAL  = 76;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_line = '0;
  logic        busy, rsp_valid, rsp_last;
  logic [31:0] rsp_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit chk_on = 0;
  bit done = 0;

  // model state
  bit          m_busy = 0;
  int          m_since = 0;
  logic [7:0]  m_line = '0;
  bit          exp_valid = 0, exp_last = 0;
  logic [31:0] exp_data = '0;

  // latency tracker from the ports
  bit busy_prev = 0;
  int t_start = 0;

  always #5 clk = ~clk;

  ilv_refill_ctrl u_ilv_refill_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_data(rsp_data)
  );

  // R7: memory formula
  function automatic logic [31:0] ref_word(int g);
    logic [63:0] t;
    t = 64'(g) * 64'h9E37_79B1 + 64'h0BAD_F00D;
    return t[31:0];
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: counts cycles since acceptance
  always @(posedge clk) begin
    cyc++;
    exp_valid = 0;
    exp_last  = 0;
    if (rst) begin
      m_busy = 0;
    end else if (!m_busy) begin
      if (req_valid) begin
        m_busy  = 1;
        m_since = 0;
        m_line  = req_line;
      end
    end else begin
      m_since++;
      if (m_since >= FIRST && (m_since - FIRST) % STEP == 0) begin
        automatic int k = (m_since - FIRST) / STEP;
        exp_valid = 1;
        exp_data  = ref_word(int'(m_line) * WORDS + k);
        exp_last  = (k == WORDS - 1);
        if (k == WORDS - 1) m_busy = 0;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !rst && !done) begin
      check(busy === m_busy, "R3", "busy", busy, m_busy);
      check(rsp_valid === exp_valid, "R4", "rsp_valid", rsp_valid, exp_valid);
      check(rsp_last === exp_last, "R5", "rsp_last", rsp_last, exp_last);
      if (exp_valid)
        check(rsp_data === exp_data, "R6", "rsp_data", rsp_data, exp_data);
      if (busy && !busy_prev) t_start = cyc;
      if (rsp_last)
        check(cyc - t_start == TOTAL, "R5", "last-word latency", cyc - t_start, TOTAL);
      busy_prev = busy;
    end
  end

  task automatic send(logic [7:0] line);
    @(negedge clk);
    req_valid = 1'b1;
    req_line  = line;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(posedge clk);
    chk_on = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1
    check(!busy && !rsp_valid && !rsp_last, "R1", "outputs in reset",
          {busy, rsp_valid, rsp_last}, 0);
    rst = 1'b0;

    // R6 R7: plain refills, including lowest and highest lines
    send(8'd0);   wait_idle();
    send(8'd5);   wait_idle();
    send(8'd255); wait_idle();

    // R2: requests during a refill are ignored
    send(8'd3);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_line = 8'd9;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    req_valid = 1'b1; req_line = 8'd77;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R2", "busy after ignored requests", busy, 0);

    // R8: request held high across the end of a refill
    @(negedge clk);
    req_valid = 1'b1; req_line = 8'd170;
    do @(negedge clk); while (!rsp_last);
    req_line = 8'd171;
    @(negedge clk);
    check(busy === 1'b1, "R8", "back-to-back acceptance", busy, 1);
    req_valid = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule